// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer. A dual-modulus prescaler is modelled in logic and works together with a main count B and a swallow count A. For each output frame the prescaler divides by P+1 for the first A of its periods and by P for the remaining B−A periods. The block emits a one-cycle pulse every N = B·P + A input clocks. P is 8 or 16, and the `wide_mode` input selects which.

A new divide word is checked for legality on every cycle. It is adopted only at a frame boundary. An illegal word raises a flag, and the divider keeps running at the last legal ratio. A power-down request stops the divider and holds the pulse output low. The request takes effect either at once or at the end of the current frame, depending on a timing input.

Top module: `pulse_swallow_div`

## Requirements
- R1: While running with a fixed legal ratio, `div_pulse` is high for exactly one cycle in every N input clock cycles, where N = B·P + A.
- R2: The divide word is decoded as B = word[16:4]. With `wide_mode`=1, P is 16 and A = word[3:0]. With `wide_mode`=0, P is 8, A = word[2:0], and word[3] is a reserved bit.
- R3: A word is legal only if B ≥ 3 and B ≥ A. With `wide_mode`=0 it must also have word[3] = 0.
- R4: `bad_word` is high in the cycle after an illegal word and mode are presented. It is low in the cycle after a legal pair is presented.
- R5: If an illegal word is present at a frame boundary, the previous legal ratio is used for the next frame. If no legal word has been seen since reset, no pulses are produced.
- R6: A change of word or mode takes effect only at a frame boundary. The frame in progress completes at the old ratio.
- R7: With `pwr_dn`=1 and `pd_now`=1, `pd_state` is high after the next clock edge. Counting stops and no pulse is produced.
- R8: With `pwr_dn`=1 and `pd_now`=0, power-down waits for the end of the current frame. That frame's pulse is still produced, in the same cycle in which `pd_state` rises. If the divider is idle, power-down is entered at the next edge.
- R9: While powered down, `div_pulse` stays low. After `pwr_dn` returns to 0, `pd_state` clears at the next edge and a full new frame starts.
- R10: Active-low synchronous reset clears `div_pulse`, `bad_word` and `pd_state`, and discards any held ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| div_word | input | B_W+4 | Divide word (17 bits by default) |
| wide_mode | input | 1 | Prescaler select: 0 gives 8/9, 1 gives 16/17 |
| pwr_dn | input | 1 | Power-down request |
| pd_now | input | 1 | 1: immediate power-down, 0: deferred to frame end |
| div_pulse | output | 1 | One-cycle divided output pulse |
| bad_word | output | 1 | Illegal divide word flag |
| pd_state | output | 1 | Powered-down status |

## Verification
The bench builds the block with the default B_W of 13, which gives a 17-bit word. This reaches both prescaler modes and the full low range of each, where legality gaps are densest. It sweeps every N from 24 to 130 in 8/9 mode and from 48 to 260 in 16/17 mode. It also exercises words that break each legality rule, including the reserved bit, and a word change in the middle of a frame. Immediate and deferred power-down entry and wake are covered. Ratios with large B are left out, because a single period at the maximum N would exceed the run length.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int B_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [B_W+3:0]   div_word,
  input  logic             wide_mode,
  input  logic             pwr_dn,
  input  logic             pd_now,
  output logic             div_pulse,
  output logic             bad_word,
  output logic             pd_state
);
  localparam int W = B_W + 4;

  logic [B_W-1:0] in_b, cfg_b, nb, b_left;
  logic [3:0]     in_a, cfg_a, na, a_left;
  logic [4:0]     pre_cnt, plen_new, plen_run;
  logic           in_ok, cfg_wide, nwide, have_cfg, running;
  logic           frame_end, period_end, boundary, start_ok;

  assign in_b  = div_word[W-1:4];
  assign in_a  = wide_mode ? div_word[3:0] : {1'b0, div_word[2:0]};
  assign in_ok = (in_b >= B_W'(3)) && (in_b >= B_W'(in_a)) && (wide_mode || !div_word[3]);

  assign nb    = in_ok ? in_b : cfg_b;
  assign na    = in_ok ? in_a : cfg_a;
  assign nwide = in_ok ? wide_mode : cfg_wide;
  assign start_ok = in_ok || have_cfg;

  assign period_end = running && (pre_cnt == 5'd0);
  assign frame_end  = period_end && (b_left == B_W'(1));
  assign boundary   = !running || frame_end;

  // first prescaler period: swallow (P+1) if A > 0, else plain P
  assign plen_new = (nwide ? 5'd16 : 5'd8) - {4'd0, na == 4'd0};
  assign plen_run = (cfg_wide ? 5'd16 : 5'd8) - {4'd0, a_left <= 4'd1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_pulse <= 1'b0;
      bad_word  <= 1'b0;
      pd_state  <= 1'b0;
      running   <= 1'b0;
      have_cfg  <= 1'b0;
      cfg_b     <= '0;
      cfg_a     <= '0;
      cfg_wide  <= 1'b0;
      pre_cnt   <= '0;
      a_left    <= '0;
      b_left    <= '0;
    end else begin
      bad_word  <= !in_ok;
      div_pulse <= 1'b0;
      if (pd_state) begin
        running <= 1'b0;
        if (!pwr_dn) pd_state <= 1'b0;
      end else if (pwr_dn && (pd_now || boundary)) begin
        pd_state  <= 1'b1;
        running   <= 1'b0;
        div_pulse <= frame_end && !pd_now;
      end else if (boundary) begin
        div_pulse <= frame_end;
        if (start_ok) begin
          running  <= 1'b1;
          have_cfg <= 1'b1;
          cfg_b    <= nb;
          cfg_a    <= na;
          cfg_wide <= nwide;
          b_left   <= nb;
          a_left   <= na;
          pre_cnt  <= plen_new;
        end else begin
          running  <= 1'b0;
        end
      end else if (period_end) begin
        b_left  <= b_left - B_W'(1);
        if (a_left != 4'd0) a_left <= a_left - 4'd1;
        pre_cnt <= plen_run;
      end else begin
        pre_cnt <= pre_cnt - 5'd1;
      end
    end
  end

  assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_low_b_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_word[W-1:4] < B_W'(3)) |=> bad_word);

  assert_reserved_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && div_word[3]) |=> bad_word);

  assert_no_cfg_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !have_cfg |-> !div_pulse);

  assert_pd_immediate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && pd_now) |=> (pd_state && !div_pulse));

  assert_pd_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !pd_now && !pd_state && running && !frame_end) |=> !pd_state);

  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state && $past(pd_state)) |-> !div_pulse);
endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
  localparam int CLK_PERIOD = 10;
  localparam int B_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [B_W+3:0] div_word = '0;
  logic wide_mode = 1'b0, pwr_dn = 1'b0, pd_now = 1'b0;
  logic div_pulse, bad_word, pd_state;

  int checks = 0, errors = 0, cyc = 0;

  pulse_swallow_div #(.B_W(B_W)) dut (
    .clk(clk), .rst_n(rst_n), .div_word(div_word), .wide_mode(wide_mode),
    .pwr_dn(pwr_dn), .pd_now(pd_now),
    .div_pulse(div_pulse), .bad_word(bad_word), .pd_state(pd_state));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_n = 0, m_cnt = 0;
  bit m_run = 0, m_have = 0, m_pd = 0, m_pulse = 0, m_bad = 0, started = 0;

  function automatic bit legal_in(logic [B_W+3:0] w, logic wide);
    int b, a;
    b = int'(w[B_W+3:4]);
    a = wide ? int'(w[3:0]) : int'(w[2:0]);
    return (b >= 3) && (b >= a) && (wide || !w[3]);
  endfunction

  function automatic int n_of(logic [B_W+3:0] w, logic wide);
    int b;
    b = int'(w[B_W+3:4]);
    return wide ? b * 16 + int'(w[3:0]) : b * 8 + int'(w[2:0]);
  endfunction

  function automatic logic [B_W+3:0] mk_word(int n, bit wide);
    logic [B_W+3:0] w;
    if (wide) w = (B_W+4)'(n);
    else w = {B_W'(n / 8), 1'b0, 3'(n % 8)};
    return w;
  endfunction

  always @(posedge clk) begin
    bit fe, bnd, ok;
    cyc++;
    started = 1;
    if (!rst_n) begin
      m_run = 0; m_have = 0; m_pd = 0; m_pulse = 0; m_bad = 0; m_cnt = 0; m_n = 0;
    end else begin
      ok = legal_in(div_word, wide_mode);
      m_bad = !ok;
      m_pulse = 0;
      fe = m_run && (m_cnt == m_n - 1);
      bnd = !m_run || fe;
      if (m_pd) begin
        m_run = 0;
        if (!pwr_dn) m_pd = 0;
      end else if (pwr_dn && (pd_now || bnd)) begin
        m_pd = 1; m_run = 0; m_pulse = fe && !pd_now;
      end else if (bnd) begin
        m_pulse = fe;
        if (ok) begin m_n = n_of(div_word, wide_mode); m_run = 1; m_cnt = 0; m_have = 1; end
        else if (m_have) begin m_run = 1; m_cnt = 0; end
        else m_run = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R1 pulse vs model", int'(div_pulse), int'(m_pulse));
      chk("R4 bad_word vs model", int'(bad_word), int'(m_bad));
      chk("R7 pd_state vs model", int'(pd_state), int'(m_pd));
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_pulse(output int t);
    do @(negedge clk); while (!div_pulse);
    t = cyc;
  endtask

  task automatic count_pulses(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (div_pulse) c++;
    end
  endtask

  task automatic measure(int exp, string tag);
    int t0, t1;
    wait_pulse(t0);
    wait_pulse(t1);
    chk(tag, t1 - t0, exp);
  endtask

  initial begin
    int t0, t1, c, b, a;
    step(3);
    chk("R10 reset pulse", int'(div_pulse), 0);
    chk("R10 reset bad", int'(bad_word), 0);
    chk("R10 reset pd", int'(pd_state), 0);
    // no legal word since reset: silent (R5)
    div_word = mk_word(20, 0);
    rst_n = 1'b1;
    count_pulses(100, c);
    chk("R5 no pulses without legal ratio", c, 0);
    chk("R4 flag for N=20", int'(bad_word), 1);

    // R1 R2 sweep in 8/9 mode
    for (int n = 24; n <= 130; n++) begin
      b = n / 8; a = n % 8;
      if (b >= 3 && b >= a) begin
        wide_mode = 1'b0;
        div_word = mk_word(n, 0);
        wait_pulse(t0);
        measure(n, "R1 R2 period 8/9");
      end
    end
    // R1 R2 sweep in 16/17 mode
    for (int n = 48; n <= 260; n++) begin
      b = n / 16; a = n % 16;
      if (b >= 3 && b >= a) begin
        wide_mode = 1'b1;
        div_word = mk_word(n, 1);
        wait_pulse(t0);
        measure(n, "R1 R2 period 16/17");
      end
    end

    // R3 R5: illegal words keep the last ratio (wide, N=100)
    wide_mode = 1'b1; div_word = mk_word(100, 1);
    wait_pulse(t0); measure(100, "R1 base");
    div_word = mk_word(47, 1);          // B=2
    step(2); chk("R3 B<3 flagged", int'(bad_word), 1);
    measure(100, "R5 ratio held after B<3");
    div_word = mk_word(63, 1);          // B=3, A=15
    step(2); chk("R3 B<A flagged", int'(bad_word), 1);
    measure(100, "R5 ratio held after B<A");
    wide_mode = 1'b0; div_word = {B_W'(5), 1'b1, 3'd2};   // reserved bit set
    step(2); chk("R3 reserved bit flagged", int'(bad_word), 1);
    measure(100, "R5 ratio held after reserved bit");
    div_word = mk_word(42, 0);
    step(2); chk("R4 flag clears on legal word", int'(bad_word), 0);

    // R6 mid-frame change
    wide_mode = 1'b1; div_word = mk_word(150, 1);
    wait_pulse(t0); wait_pulse(t0);
    step(5);
    div_word = mk_word(200, 1);
    wait_pulse(t1);
    chk("R6 frame finishes at old ratio", t1 - t0, 150);
    measure(200, "R6 new ratio after boundary");

    // R7 immediate power-down
    wait_pulse(t0); step(10);
    pwr_dn = 1'b1; pd_now = 1'b1;
    step(1);
    chk("R7 immediate pd_state", int'(pd_state), 1);
    count_pulses(300, c);
    chk("R9 no pulses while down", c, 0);
    pwr_dn = 1'b0; pd_now = 1'b0;
    step(1);
    chk("R9 pd_state clears", int'(pd_state), 0);
    wait_pulse(t0); measure(200, "R9 full frames after wake");

    // R8 deferred power-down
    wait_pulse(t0); step(10);
    pwr_dn = 1'b1; pd_now = 1'b0;
    step(5);
    chk("R8 still running before frame end", int'(pd_state), 0);
    wait_pulse(t1);
    chk("R8 last pulse at frame end", t1 - t0, 200);
    chk("R8 pd_state with last pulse", int'(pd_state), 1);
    count_pulses(250, c);
    chk("R9 quiet after deferred pd", c, 0);

    // wake with illegal word: old ratio resumes (R5)
    div_word = mk_word(47, 1);
    pwr_dn = 1'b0;
    wait_pulse(t0); measure(200, "R5 old ratio after wake");

    // R10 reset discards held ratio
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    count_pulses(300, c);
    chk("R10 no held ratio after reset", c, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule